// File: doc/BRIEF.md
# Dual-Channel Microstep Register Interface

This block sits between a byte-wide microprocessor bus and the two current channels of a microstepping motor driver. A host writes bytes through an active-low chip select, a write strobe and a two-bit address. Each channel holds a direction bit, a 7-bit current magnitude code and a 3-bit decay threshold. The direction and magnitude go to the channel's converter. The threshold is used only inside the block.

Every time a channel's magnitude is loaded, the block also loads a fast-decay request for that channel. The request is active low. It is raised only when the winding current is being stepped down and the new code's upper three bits are below the threshold set for that channel. The analog side uses this flag to speed up the fall of the current at high step rates.

The bus inputs are sampled on the system clock. A write takes effect on the clock edge at which the strobe is first seen high. All outputs come straight from registers and hold their values between writes.

Top module: `microstep_regif`

## Requirements
- R1: A register is loaded only on the first clock edge at which `bus_wr` is seen high after being low. Holding `bus_wr` high for more cycles loads nothing further, even if `bus_data` changes.
- R2: With `bus_cs_n` low and `bus_addr` = 2'b00, the write sets `ch1_sign` to `bus_data[7]` and `ch1_mag` to `bus_data[6:0]`.
- R3: With `bus_cs_n` low and `bus_addr` = 2'b10, the write sets the channel 1 threshold to `bus_data[6:4]`. No output changes as a result of this write.
- R4: With `bus_cs_n` low, `bus_addr` = 2'b01 loads `ch2_sign` and `ch2_mag` from bits 7 and 6:0, and `bus_addr` = 2'b11 loads the channel 2 threshold from bits 6:4. Bit 0 of the address selects the channel and bit 1 selects the threshold register.
- R5: With `bus_cs_n` high, a strobe changes no register, whatever the address shows.
- R6: On a magnitude write, the channel's `_fast_n` goes low only if both of these hold: the new 7-bit code is strictly below the code held just before the write, and the new code's bits 6:4 are strictly below that channel's threshold. In every other case, including equal codes, it goes high.
- R7: A channel's `_fast_n` changes only on a write to that channel's magnitude. Threshold writes and writes to the other channel leave it unchanged.
- R8: The sign bit takes no part in either comparison.
- R9: While `rst_n` is low, all magnitudes, signs and thresholds are cleared to zero, and both `_fast_n` outputs are high.
- R10: Outputs stay stable on every cycle that has no accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr | input | 1 | Write strobe; its rising edge commits a write |
| bus_addr | input | 2 | Bit 0 selects the channel, bit 1 selects the threshold register |
| bus_data | input | 8 | Write data |
| ch1_sign | output | 1 | Channel 1 current direction |
| ch1_mag | output | 7 | Channel 1 current magnitude code |
| ch1_fast_n | output | 1 | Channel 1 fast-decay request, active low |
| ch2_sign | output | 1 | Channel 2 current direction |
| ch2_mag | output | 7 | Channel 2 current magnitude code |
| ch2_fast_n | output | 1 | Channel 2 fast-decay request, active low |

## Verification
The bound checker watches every clock edge. It checks the address-to-register mapping for sign and magnitude loads, and the blocking effect of chip select. It checks that the decay flags hold between magnitude writes and that each flag matches the two-way comparison. For that comparison it keeps its own copy of the thresholds, built from the bus. The thresholds themselves never reach a port. So the bench scenarios are what show that threshold writes go to the right channel, including the boundary values 0 and 7. The bench scenarios also cover the single-load behaviour of a strobe held high while data changes, and the exclusion of the sign bit when a sign flip would otherwise invert the result.

// File: rtl/msr_pkg.sv
package msr_pkg;

    // Default geometry of the register interface
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_MAG_W  = 7;
    localparam int unsigned DEF_LVL_W  = 3;
    localparam int unsigned DEF_NUM_CH = 2;

    // Address bit roles: one bit picks the channel, the other the register kind
    localparam int unsigned ADDR_W       = 2;
    localparam int unsigned ADDR_CH_BIT  = 0;
    localparam int unsigned ADDR_KND_BIT = 1;

    typedef enum logic {
        KIND_MAG = 1'b0,
        KIND_LVL = 1'b1
    } reg_kind_e;

    // Registered state of the strobe front end
    typedef struct packed {
        logic wr_seen;
    } strobe_state_t;

endpackage

// File: rtl/msr_bus_decode.sv
module msr_bus_decode
    import msr_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ld_mag,
    output logic [NUM_CH-1:0] ld_lvl
);

    strobe_state_t st_d, st_q;
    logic          commit;
    reg_kind_e     kind;
    logic          ch_sel;

    always_comb begin
        st_d         = st_q;
        st_d.wr_seen = wr;
        commit       = wr && !st_q.wr_seen && !cs_n;
        kind         = reg_kind_e'(addr[ADDR_KND_BIT]);
        ch_sel       = addr[ADDR_CH_BIT];
        ld_mag       = '0;
        ld_lvl       = '0;
        for (int c = 0; c < int'(NUM_CH); c++) begin
            if (commit && (ch_sel == c[0])) begin
                ld_mag[c] = (kind == KIND_MAG);
                ld_lvl[c] = (kind == KIND_LVL);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/msr_channel.sv
module msr_channel #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned MAG_W  = 7,
    parameter int unsigned LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mag,
    input  logic              ld_lvl,
    input  logic [DATA_W-1:0] data,
    output logic              sign,
    output logic [MAG_W-1:0]  mag,
    output logic              fast_n
);

    localparam int unsigned SIGN_BIT = DATA_W - 1;
    localparam int unsigned TOP_BIT  = MAG_W - 1;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic [LVL_W-1:0] lvl;
        logic             fast_n;
    } chan_state_t;

    chan_state_t      st_d, st_q;
    logic [MAG_W-1:0] new_mag;
    logic [LVL_W-1:0] new_top;
    logic             falling;
    logic             below_lvl;

    always_comb begin
        st_d      = st_q;
        new_mag   = data[MAG_W-1:0];
        new_top   = new_mag[TOP_BIT -: LVL_W];
        falling   = new_mag < st_q.mag;
        below_lvl = new_top < st_q.lvl;
        if (ld_mag) begin
            st_d.sign   = data[SIGN_BIT];
            st_d.mag    = new_mag;
            st_d.fast_n = !(falling && below_lvl);
        end
        if (ld_lvl) begin
            st_d.lvl = data[TOP_BIT -: LVL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.fast_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sign   = st_q.sign;
    assign mag    = st_q.mag;
    assign fast_n = st_q.fast_n;

endmodule

// File: rtl/microstep_regif.sv
module microstep_regif
    import msr_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned MAG_W  = DEF_MAG_W,
    parameter int unsigned LVL_W  = DEF_LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              ch1_sign,
    output logic [MAG_W-1:0]  ch1_mag,
    output logic              ch1_fast_n,
    output logic              ch2_sign,
    output logic [MAG_W-1:0]  ch2_mag,
    output logic              ch2_fast_n
);

    localparam int unsigned NUM_CH = DEF_NUM_CH;

    logic [NUM_CH-1:0] ld_mag;
    logic [NUM_CH-1:0] ld_lvl;
    logic [NUM_CH-1:0] sign_v;
    logic [NUM_CH-1:0] fast_v;
    logic [MAG_W-1:0]  mag_v [NUM_CH];

    msr_bus_decode #(
        .NUM_CH (NUM_CH)
    ) decode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (bus_cs_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .ld_mag (ld_mag),
        .ld_lvl (ld_lvl)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        msr_channel #(
            .DATA_W (DATA_W),
            .MAG_W  (MAG_W),
            .LVL_W  (LVL_W)
        ) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_mag (ld_mag[c]),
            .ld_lvl (ld_lvl[c]),
            .data   (bus_data),
            .sign   (sign_v[c]),
            .mag    (mag_v[c]),
            .fast_n (fast_v[c])
        );
    end

    assign ch1_sign   = sign_v[0];
    assign ch1_mag    = mag_v[0];
    assign ch1_fast_n = fast_v[0];
    assign ch2_sign   = sign_v[1];
    assign ch2_mag    = mag_v[1];
    assign ch2_fast_n = fast_v[1];

endmodule

// File: rtl/microstep_regif_chk.sv
module microstep_regif_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned MAG_W  = 7,
    parameter int unsigned LVL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              ch1_sign,
    input logic [MAG_W-1:0]  ch1_mag,
    input logic              ch1_fast_n,
    input logic              ch2_sign,
    input logic [MAG_W-1:0]  ch2_mag,
    input logic              ch2_fast_n
);

    logic             strobe_prev;
    logic [LVL_W-1:0] thr1, thr2;
    logic             go;

    assign go = bus_wr && !strobe_prev && !bus_cs_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_prev <= 1'b0;
            thr1        <= '0;
            thr2        <= '0;
        end else begin
            strobe_prev <= bus_wr;
            if (go && bus_addr == 2'b10) thr1 <= bus_data[MAG_W-1 -: LVL_W];
            if (go && bus_addr == 2'b11) thr2 <= bus_data[MAG_W-1 -: LVL_W];
        end
    end

    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (ch1_mag == '0 && ch2_mag == '0 && !ch1_sign && !ch2_sign
                    && ch1_fast_n && ch2_fast_n));

    a_r2_ch1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_addr == 2'b00) |=>
            (ch1_mag == $past(bus_data[MAG_W-1:0]) && ch1_sign == $past(bus_data[DATA_W-1])));

    a_r4_ch2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_addr == 2'b01) |=>
            (ch2_mag == $past(bus_data[MAG_W-1:0]) && ch2_sign == $past(bus_data[DATA_W-1])));

    a_r5_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(ch1_mag) && $stable(ch2_mag) && $stable(ch1_sign)
                 && $stable(ch2_sign) && $stable(ch1_fast_n) && $stable(ch2_fast_n)));

    a_r6_ch1_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_addr == 2'b00) |=>
            (ch1_fast_n == !(($past(bus_data[MAG_W-1:0]) < $past(ch1_mag))
                             && ($past(bus_data[MAG_W-1 -: LVL_W]) < $past(thr1)))));

    a_r6_ch2_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bus_addr == 2'b01) |=>
            (ch2_fast_n == !(($past(bus_data[MAG_W-1:0]) < $past(ch2_mag))
                             && ($past(bus_data[MAG_W-1 -: LVL_W]) < $past(thr2)))));

    a_r7_ch1_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && bus_addr == 2'b00) |=> $stable(ch1_fast_n));

    a_r7_ch2_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && bus_addr == 2'b01) |=> $stable(ch2_fast_n));

endmodule

bind microstep_regif microstep_regif_chk #(
    .DATA_W (DATA_W),
    .MAG_W  (MAG_W),
    .LVL_W  (LVL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .ch1_sign   (ch1_sign),
    .ch1_mag    (ch1_mag),
    .ch1_fast_n (ch1_fast_n),
    .ch2_sign   (ch2_sign),
    .ch2_mag    (ch2_mag),
    .ch2_fast_n (ch2_fast_n)
);

// File: tb/microstep_regif_tb_top.sv
module microstep_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic [7:0] bus_data = 8'h00;
    logic       ch1_sign, ch2_sign, ch1_fast_n, ch2_fast_n;
    logic [6:0] ch1_mag, ch2_mag;

    int checks = 0;
    int failures = 0;

    // Bench-side expectation per channel (index 0 = channel 1)
    logic       e_sign [2];
    logic [6:0] e_mag  [2];
    logic [2:0] e_lvl  [2];
    logic       e_fast [2];

    always #2 clk = ~clk;

    microstep_regif dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_cs_n   (bus_cs_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .ch1_sign   (ch1_sign),
        .ch1_mag    (ch1_mag),
        .ch1_fast_n (ch1_fast_n),
        .ch2_sign   (ch2_sign),
        .ch2_mag    (ch2_mag),
        .ch2_fast_n (ch2_fast_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " ch1 sign"}, int'(ch1_sign),   int'(e_sign[0]));
        chk({req, " ch1 mag"},  int'(ch1_mag),    int'(e_mag[0]));
        chk({req, " ch1 fast"}, int'(ch1_fast_n), int'(e_fast[0]));
        chk({req, " ch2 sign"}, int'(ch2_sign),   int'(e_sign[1]));
        chk({req, " ch2 mag"},  int'(ch2_mag),    int'(e_mag[1]));
        chk({req, " ch2 fast"}, int'(ch2_fast_n), int'(e_fast[1]));
    endtask

    // One strobe pulse; updates the expectation from the requirements
    task automatic bus_write(input logic cs_n, input logic [1:0] a, input logic [7:0] d);
        int ch;
        @(negedge clk);
        bus_cs_n = cs_n; bus_addr = a; bus_data = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_cs_n = 1'b1;
        if (!cs_n) begin
            ch = int'(a[0]);
            if (a[1]) begin
                e_lvl[ch] = d[6:4];
            end else begin
                e_fast[ch] = !((d[6:0] < e_mag[ch]) && (d[6:4] < e_lvl[ch]));
                e_sign[ch] = d[7];
                e_mag[ch]  = d[6:0];
            end
        end
    endtask

    task automatic t_reset;
        for (int c = 0; c < 2; c++) begin
            e_sign[c] = 1'b0; e_mag[c] = '0; e_lvl[c] = '0; e_fast[c] = 1'b1;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R10 idle after reset");
    endtask

    task automatic t_addr_map;
        bus_write(1'b0, 2'b00, 8'hA5);
        chk_all("R2 ch1 load");
        chk("R2 ch1 mag literal", int'(ch1_mag), 'h25);
        bus_write(1'b0, 2'b01, 8'h3C);
        chk_all("R4 ch2 load");
        bus_write(1'b0, 2'b10, 8'h70);
        chk_all("R3 ch1 level write leaves outputs");
        bus_write(1'b0, 2'b11, 8'h70);
        chk_all("R4 ch2 level write leaves outputs");
        repeat (4) @(negedge clk);
        chk_all("R10 stable between writes");
    endtask

    task automatic t_cs_high;
        for (int a = 0; a < 4; a++) begin
            bus_write(1'b1, a[1:0], 8'h00);
            chk_all("R5 cs high ignored");
        end
    endtask

    task automatic t_strobe_held;
        @(negedge clk);
        bus_cs_n = 1'b0; bus_addr = 2'b00; bus_data = 8'h46; bus_wr = 1'b1;
        @(negedge clk);
        bus_data = 8'h91;
        repeat (3) @(negedge clk);
        bus_wr = 1'b0; bus_cs_n = 1'b1;
        e_fast[0] = !((7'h46 < e_mag[0]) && (3'h4 < e_lvl[0]));
        e_sign[0] = 1'b0; e_mag[0] = 7'h46;
        chk_all("R1 held strobe loads once");
        chk("R1 mag is first value", int'(ch1_mag), 'h46);
    endtask

    task automatic t_decay;
        // ch1 level is 7 here
        bus_write(1'b0, 2'b00, 8'h50);
        bus_write(1'b0, 2'b00, 8'h50);
        chk("R6 equal codes no fast decay", int'(ch1_fast_n), 1);
        bus_write(1'b0, 2'b00, 8'h30);
        chk("R6 falling below level 7", int'(ch1_fast_n), 0);
        chk_all("R6 model");
        bus_write(1'b0, 2'b00, 8'h40);
        chk("R6 rising", int'(ch1_fast_n), 1);
        bus_write(1'b0, 2'b00, 8'h7F);
        bus_write(1'b0, 2'b00, 8'h70);
        chk("R6 top bits 7 not below level 7", int'(ch1_fast_n), 1);
        bus_write(1'b0, 2'b10, 8'h00);
        bus_write(1'b0, 2'b00, 8'h05);
        chk("R6 level 0 never fast", int'(ch1_fast_n), 1);
        bus_write(1'b0, 2'b10, 8'h30);
        bus_write(1'b0, 2'b00, 8'h40);
        bus_write(1'b0, 2'b00, 8'h30);
        chk("R6 top bits equal to level", int'(ch1_fast_n), 1);
        bus_write(1'b0, 2'b00, 8'h2F);
        chk("R6 top bits just below level", int'(ch1_fast_n), 0);
        chk_all("R6 model after level 3");
    endtask

    task automatic t_isolation;
        // ch1 flag is low here
        bus_write(1'b0, 2'b10, 8'h00);
        chk("R7 level write keeps flag", int'(ch1_fast_n), 0);
        bus_write(1'b0, 2'b01, 8'h01);
        chk("R7 other channel keeps flag", int'(ch1_fast_n), 0);
        chk_all("R7 model");
    endtask

    task automatic t_sign_excluded;
        bus_write(1'b0, 2'b11, 8'h70);
        bus_write(1'b0, 2'b01, 8'h10);
        bus_write(1'b0, 2'b01, 8'h85);
        chk("R8 sign set, magnitude falls", int'(ch2_fast_n), 0);
        bus_write(1'b0, 2'b01, 8'h90);
        bus_write(1'b0, 2'b01, 8'h11);
        chk("R8 sign cleared, magnitude rises", int'(ch2_fast_n), 1);
        chk_all("R8 model");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_addr_map();
        t_cs_high();
        t_strobe_held();
        t_decay();
        t_isolation();
        t_sign_excluded();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule